// File: doc/BRIEF.md
# Oldest-First Wait/Ready Issue Queue

This block holds instructions that have been dispatched but not yet completed. Each one is known only by its instruction index. A slot can be in one of three live pools: waiting for operands, ready to issue, or executing. An instruction whose operands are already present at dispatch goes straight to the ready pool. Otherwise it waits until a wakeup naming its index arrives. The promotion takes effect at the next clock edge, so the entry can compete for issue from the following cycle on.

In each cycle the queue grants at most one ready entry. Only entries whose execution resource is free take part, and among those the one with the oldest index wins. Age is decided by a wrap-aware subtraction, so index numbering may roll over. A granted entry stays counted in the occupancy until a write-back naming its index releases the slot. When every slot is taken, the dispatch-ready output is low and any dispatch attempt is refused and flagged as a stall.

Top module: `iq_issue_queue`

## Requirements
- R1: After reset the queue is empty: occupancy is 0, `disp_ready` is 1 and `iss_valid` is 0.
- R2: A dispatch accepted with `disp_opnd_rdy`=1 enters the ready pool at the next edge and adds one to `occupancy` at that edge.
- R3: A dispatch accepted with `disp_opnd_rdy`=0 is never issued until a wakeup (`wake_valid`=1, `wake_idx` equal to its index) arrives. It can be issued in the cycle after the wakeup.
- R4: Among eligible ready entries, the oldest is granted. Entry a is older than entry b when bit IDXW-1 of (a - b) modulo 2^IDXW is 1, so index 62 is older than 63, and 63 is older than 1, when IDXW=6.
- R5: A ready entry is eligible only while `res_avail[r]` is 1, where r is the resource number given at its dispatch. A blocked older entry does not stop a younger eligible one from issuing.
- R6: At most one entry is granted per cycle. A granted entry moves to executing, is never granted again, and still counts in `occupancy`.
- R7: A write-back (`wb_valid`=1) naming an executing entry frees its slot and lowers `occupancy` by one at the next edge. A write-back naming no executing entry has no effect.
- R8: With all DEPTH slots in use, `disp_ready` is 0. A dispatch attempt then raises `disp_stall` and is dropped: `occupancy` is unchanged and the index never issues.
- R9: A wakeup naming an index that is not in the wait pool has no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | IDXW | Index of the dispatched instruction |
| disp_opnd_rdy | input | 1 | All operands already available at dispatch |
| disp_res | input | log2(NRES) | Execution resource the instruction needs |
| disp_ready | output | 1 | A free slot exists |
| disp_stall | output | 1 | Dispatch requested but refused |
| wake_valid | input | 1 | Operand wakeup strobe |
| wake_idx | input | IDXW | Index whose operands are now complete |
| res_avail | input | NRES | Per-resource availability |
| wb_valid | input | 1 | Write-back strobe |
| wb_idx | input | IDXW | Index that reached write-back |
| iss_valid | output | 1 | An entry is granted this cycle |
| iss_idx | output | IDXW | Index of the granted entry |
| occupancy | output | log2(DEPTH+1) | Number of occupied slots |

## Verification
A scoreboard holds the expected order of grants and compares it with every grant. Several patterns are used. A plain mixed batch separates direct entry into the ready pool from waiting entries. A batch where one resource is blocked shows that a stuck older entry does not hold back a younger eligible one. A batch whose indices straddle the rollover point tells a wrap-aware age compare apart from a plain magnitude compare. A full queue that is then woken out of order shows that grant order follows age and not wakeup order, and that refused dispatches and stray wakeups leave no trace.

// File: rtl/iq_pkg.sv
package iq_pkg;
   typedef enum logic [1:0] {
      ST_FREE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_READY = 2'd2,
      ST_EXEC  = 2'd3
   } slot_state_e;
endpackage

// File: rtl/iq_slot.sv
module iq_slot
   import iq_pkg::*;
#(
   parameter int unsigned IDXW = 6,
   parameter int unsigned RESW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc,
   input  logic [IDXW-1:0] alloc_idx,
   input  logic            alloc_opnd_rdy,
   input  logic [RESW-1:0] alloc_res,
   input  logic            wake_valid,
   input  logic [IDXW-1:0] wake_idx,
   input  logic            grant,
   input  logic            wb_valid,
   input  logic [IDXW-1:0] wb_idx,
   output slot_state_e     st,
   output logic [IDXW-1:0] idx,
   output logic [RESW-1:0] res,
   output logic            wb_hit
);
   logic wake_hit;

   assign wake_hit = (st == ST_WAIT) && wake_valid && (wake_idx == idx);
   assign wb_hit   = (st == ST_EXEC) && wb_valid && (wb_idx == idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ST_FREE;
         idx <= '0;
         res <= '0;
      end else begin
         unique case (st)
            ST_FREE: if (alloc) begin
               st  <= alloc_opnd_rdy ? ST_READY : ST_WAIT;
               idx <= alloc_idx;
               res <= alloc_res;
            end
            ST_WAIT:  if (wake_hit) st <= ST_READY;
            ST_READY: if (grant)    st <= ST_EXEC;
            ST_EXEC:  if (wb_hit)   st <= ST_FREE;
            default:  st <= ST_FREE;
         endcase
      end
   end

   // R6: the picker may only grant a slot that is in the ready pool
   a_r6_grant_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> st == ST_READY);
   // R8: allocation only lands in a free slot
   a_r8_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> st == ST_FREE);
   // R3: a waiting entry stays waiting until its own wakeup
   a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && !(wake_valid && wake_idx == idx)) |=> st == ST_WAIT);
   // R7: an executing entry stays until its own write-back
   a_r7_exec_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EXEC && !(wb_valid && wb_idx == idx)) |=> st == ST_EXEC);
endmodule

// File: rtl/iq_age_pick.sv
module iq_age_pick #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned IDXW  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] elig,
   input  logic [IDXW-1:0]  idx_in [DEPTH],
   output logic             any,
   output logic [DEPTH-1:0] sel_vec,
   output logic [IDXW-1:0]  sel_idx
);
   function automatic logic is_older(input logic [IDXW-1:0] a, input logic [IDXW-1:0] b);
      logic [IDXW-1:0] d;
      d = a - b;
      return d[IDXW-1];
   endfunction

   always_comb begin
      any     = 1'b0;
      sel_vec = '0;
      sel_idx = '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (elig[i] && (!any || is_older(idx_in[i], sel_idx))) begin
            any        = 1'b1;
            sel_idx    = idx_in[i];
            sel_vec    = '0;
            sel_vec[i] = 1'b1;
         end
      end
   end

   // R4: no eligible slot may be older than the chosen one
   for (genvar g = 0; g < DEPTH; g++) begin : g_age_chk
      a_r4_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
         elig[g] |-> !is_older(idx_in[g], sel_idx));
   end
   // R6: a grant exists exactly when some slot is eligible, and it is single
   a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_vec) && (any == (|elig)));
endmodule

// File: rtl/iq_free_find.sv
module iq_free_find #(
   parameter int unsigned DEPTH = 8
) (
   input  logic [DEPTH-1:0] free_vec,
   output logic             any,
   output logic [DEPTH-1:0] pick
);
   always_comb begin
      any  = 1'b0;
      pick = '0;
      for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
         if (free_vec[i]) begin
            any     = 1'b1;
            pick    = '0;
            pick[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/iq_issue_queue.sv
module iq_issue_queue
   import iq_pkg::*;
#(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned IDXW    = 6,
   parameter int unsigned NRES    = 4,
   parameter bit          OCC_REG = 1'b1,
   localparam int unsigned RESW   = (NRES > 1) ? $clog2(NRES) : 1,
   localparam int unsigned CNTW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [IDXW-1:0]  disp_idx,
   input  logic             disp_opnd_rdy,
   input  logic [RESW-1:0]  disp_res,
   output logic             disp_ready,
   output logic             disp_stall,
   input  logic             wake_valid,
   input  logic [IDXW-1:0]  wake_idx,
   input  logic [NRES-1:0]  res_avail,
   input  logic             wb_valid,
   input  logic [IDXW-1:0]  wb_idx,
   output logic             iss_valid,
   output logic [IDXW-1:0]  iss_idx,
   output logic [CNTW-1:0]  occupancy
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("iq_issue_queue: DEPTH must be at least 2");
   end
   if (IDXW < $clog2(DEPTH) + 2) begin : g_bad_idxw
      $error("iq_issue_queue: IDXW too narrow for wrap-aware age compare");
   end
   if (NRES < 2) begin : g_bad_nres
      $error("iq_issue_queue: NRES must be at least 2");
   end

   slot_state_e      st   [DEPTH];
   logic [IDXW-1:0]  sidx [DEPTH];
   logic [RESW-1:0]  sres [DEPTH];
   logic [DEPTH-1:0] free_vec, alloc_vec, elig, grant, wb_hit;
   logic             free_any, accept;

   iq_free_find #(.DEPTH(DEPTH)) u_free (
      .free_vec (free_vec),
      .any      (free_any),
      .pick     (alloc_vec)
   );

   assign disp_ready = free_any;
   assign disp_stall = disp_valid && !free_any;
   assign accept     = disp_valid && free_any;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      iq_slot #(.IDXW(IDXW), .RESW(RESW)) u_slot (
         .clk            (clk),
         .rst_n          (rst_n),
         .alloc          (accept && alloc_vec[g]),
         .alloc_idx      (disp_idx),
         .alloc_opnd_rdy (disp_opnd_rdy),
         .alloc_res      (disp_res),
         .wake_valid     (wake_valid),
         .wake_idx       (wake_idx),
         .grant          (grant[g]),
         .wb_valid       (wb_valid),
         .wb_idx         (wb_idx),
         .st             (st[g]),
         .idx            (sidx[g]),
         .res            (sres[g]),
         .wb_hit         (wb_hit[g])
      );
      assign free_vec[g] = (st[g] == ST_FREE);
      assign elig[g]     = (st[g] == ST_READY) && res_avail[sres[g]];
   end

   iq_age_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .idx_in  (sidx),
      .any     (iss_valid),
      .sel_vec (grant),
      .sel_idx (iss_idx)
   );

   if (OCC_REG) begin : g_occ_reg
      logic [CNTW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n) cnt <= '0;
         else        cnt <= cnt + CNTW'(accept) - CNTW'(|wb_hit);
      end
      assign occupancy = cnt;
   end else begin : g_occ_pop
      always_comb begin
         occupancy = '0;
         for (int i = 0; i < int'(DEPTH); i++)
            occupancy = occupancy + CNTW'(!free_vec[i]);
      end
   end

   // R8: occupancy never exceeds the number of slots
   a_r8_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CNTW'(DEPTH));
   // R8: a refused dispatch never raises the occupancy
   a_r8_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stall |=> occupancy <= $past(occupancy));
   // R1: nothing issues from an empty queue
   a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (occupancy == '0) |-> !iss_valid);
   // R2: a dispatch with no write-back in the same cycle grows occupancy by one
   a_r2_accept_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready && !wb_valid) |=> occupancy == $past(occupancy) + 1'b1);
endmodule

// File: tb/iq_issue_queue_test.sv
`timescale 1ns/100ps
module iq_issue_queue_test;
   localparam int unsigned DEPTH = 8;
   localparam int unsigned IDXW  = 6;
   localparam int unsigned NRES  = 4;
   localparam int unsigned RESW  = 2;
   localparam int unsigned CNTW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            disp_valid = 1'b0, disp_opnd_rdy = 1'b0;
   logic [IDXW-1:0] disp_idx = '0;
   logic [RESW-1:0] disp_res = '0;
   logic            disp_ready, disp_stall;
   logic            wake_valid = 1'b0;
   logic [IDXW-1:0] wake_idx = '0;
   logic [NRES-1:0] res_avail = '0;
   logic            wb_valid = 1'b0;
   logic [IDXW-1:0] wb_idx = '0;
   logic            iss_valid;
   logic [IDXW-1:0] iss_idx;
   logic [CNTW-1:0] occupancy;

   int nchk = 0, nbad = 0;
   bit finished = 1'b0;
   logic [IDXW-1:0] exp_q [$];

   always #2.5 clk = ~clk;

   iq_issue_queue #(.DEPTH(DEPTH), .IDXW(IDXW), .NRES(NRES)) uut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_opnd_rdy(disp_opnd_rdy),
      .disp_res(disp_res), .disp_ready(disp_ready), .disp_stall(disp_stall),
      .wake_valid(wake_valid), .wake_idx(wake_idx), .res_avail(res_avail),
      .wb_valid(wb_valid), .wb_idx(wb_idx),
      .iss_valid(iss_valid), .iss_idx(iss_idx), .occupancy(occupancy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      disp_valid = 1'b0; wake_valid = 1'b0; wb_valid = 1'b0;
   endtask

   task automatic disp(input int idx, input bit rdy, input int res);
      idle();
      disp_valid = 1'b1; disp_idx = IDXW'(idx); disp_opnd_rdy = rdy; disp_res = RESW'(res);
   endtask

   task automatic wake(input int idx);
      idle();
      wake_valid = 1'b1; wake_idx = IDXW'(idx);
   endtask

   task automatic wb(input int idx);
      idle();
      wb_valid = 1'b1; wb_idx = IDXW'(idx);
   endtask

   // scoreboard monitor: every grant must match the next expected index
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && iss_valid) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R6 unexpected grant", int'(iss_idx), -1);
            else begin
               automatic logic [IDXW-1:0] e = exp_q.pop_front();
               chk(iss_idx == e, "R4 grant order", int'(iss_idx), int'(e));
            end
         end
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk(occupancy == 0, "R1 occupancy after reset", int'(occupancy), 0);
      chk(disp_ready == 1'b1, "R1 disp_ready after reset", int'(disp_ready), 1);
      chk(iss_valid == 1'b0, "R1 iss_valid after reset", int'(iss_valid), 0);

      // mixed batch: two ready, one waiting, resources held back
      disp(5, 1'b1, 0);
      disp(3, 1'b1, 1);
      disp(7, 1'b0, 0);
      idle(); #1;
      chk(occupancy == 3, "R2 occupancy after three dispatches", int'(occupancy), 3);
      chk(iss_valid == 1'b0, "R5 no grant without resources", int'(iss_valid), 0);
      idle();
      exp_q.push_back(6'd3); exp_q.push_back(6'd5);
      res_avail = '1;
      idle(); idle(); #1;
      chk(iss_valid == 1'b0, "R3 waiting entry not granted", int'(iss_valid), 0);
      exp_q.push_back(6'd7);
      wake(7);
      idle(); idle(); #1;
      chk(occupancy == 3, "R6 executing entries still counted", int'(occupancy), 3);
      wb(3);
      idle(); #1;
      chk(occupancy == 2, "R7 write-back frees slot", int'(occupancy), 2);
      wb(3);
      idle(); #1;
      chk(occupancy == 2, "R7 repeated write-back ignored", int'(occupancy), 2);
      wb(5); wb(7);
      idle(); #1;
      chk(occupancy == 0, "R7 all freed", int'(occupancy), 0);

      // blocked older entry must not hold back a younger eligible one
      res_avail = '0;
      disp(10, 1'b1, 2);
      disp(11, 1'b1, 1);
      idle();
      exp_q.push_back(6'd11);
      res_avail = 4'b0010;
      idle(); #1;
      chk(iss_valid == 1'b0, "R5 entry on busy resource held", int'(iss_valid), 0);
      idle();
      exp_q.push_back(6'd10);
      res_avail = '1;
      idle();
      wb(10); wb(11);
      idle(); #1;
      chk(occupancy == 0, "R5 batch drained", int'(occupancy), 0);

      // indices straddling rollover
      res_avail = '0;
      disp(62, 1'b1, 0);
      disp(1, 1'b1, 0);
      disp(63, 1'b1, 3);
      idle();
      exp_q.push_back(6'd62); exp_q.push_back(6'd63); exp_q.push_back(6'd1);
      res_avail = '1;
      idle(); idle(); idle();
      wb(62); wb(63); wb(1);
      idle(); #1;
      chk(occupancy == 0, "R4 wrap batch drained", int'(occupancy), 0);

      // full queue
      res_avail = '0;
      for (int k = 0; k < 8; k++) disp(20 + k, 1'b0, 0);
      idle(); #1;
      chk(disp_ready == 1'b0, "R8 disp_ready low when full", int'(disp_ready), 0);
      chk(occupancy == 8, "R8 occupancy full", int'(occupancy), 8);
      disp(30, 1'b1, 0); #1;
      chk(disp_stall == 1'b1, "R8 stall on full dispatch", int'(disp_stall), 1);
      idle();
      res_avail = '1;
      #1;
      chk(iss_valid == 1'b0, "R8 dropped dispatch never issues", int'(iss_valid), 0);
      chk(occupancy == 8, "R8 occupancy unchanged by stall", int'(occupancy), 8);
      wake(40);
      idle(); #1;
      chk(iss_valid == 1'b0, "R9 stray wakeup has no effect", int'(iss_valid), 0);
      idle();
      res_avail = '0;
      wake(27); wake(22); wake(24);
      idle();
      exp_q.push_back(6'd22); exp_q.push_back(6'd24); exp_q.push_back(6'd27);
      res_avail = '1;
      idle(); idle(); idle();
      foreach (exp_q[i]) chk(1'b0, "R4 grant missing", 0, int'(exp_q[i]));
      exp_q.push_back(6'd20); wake(20);
      exp_q.push_back(6'd21); wake(21);
      exp_q.push_back(6'd23); wake(23);
      exp_q.push_back(6'd25); wake(25);
      exp_q.push_back(6'd26); wake(26);
      idle(); idle();
      for (int k = 0; k < 8; k++) wb(20 + k);
      idle(); #1;
      chk(occupancy == 0, "R7 full batch drained", int'(occupancy), 0);
      chk(disp_ready == 1'b1, "R8 disp_ready back after drain", int'(disp_ready), 1);
      chk(exp_q.size() == 0, "R4 every expected grant seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule